// File: doc/BRIEF.md
# Selectable-Oversampling UART Receiver

This block turns an asynchronous serial line into parallel characters. It watches the incoming line at 16, 8 or 4 oversample ticks per bit. The ratio is chosen at run time. A falling edge starts the timing of a character. The block checks the start bit again at its centre, so a short glitch does not produce a false character. Every data, parity and stop bit is then sampled once, at its centre, one full bit period after the previous sample.

Each finished character is presented with a single-cycle strobe and four error flags: overrun, parity, framing and break. The consumer pulses an acknowledge input when it has taken a character. A new character that arrives before that acknowledge is flagged as an overrun. Word length, parity and the number of stop bits come from static line-control inputs. Buffering, interrupts and register access are left to the surrounding logic.

Top module: `serial_rx_frontend`

## Requirements
- R1: The line passes through a two-flop synchronizer. A character starts only on an oversample tick where the synchronized line is low and was high at the previous tick. A line that is held low therefore starts nothing until it has been seen high again.
- R2: `os_mode` selects the ticks per bit: 00 gives 16, 01 gives 8, 10 gives 4, and 11 is treated as 16. The start bit is sampled half a bit period after detection. Each later bit is sampled one full period after the one before it.
- R3: If the line is high at the start-bit centre sample, the receiver returns to idle and no strobe is produced.
- R4: `word_len` 00/01/10/11 selects 5/6/7/8 data bits, received LSB first. The bits land in `rx_data` from bit 0 upward, and unused upper bits read 0.
- R5: When `parity_on` is 1, one parity bit follows the data. `parity_even`=1 requires even parity and 0 requires odd parity over the data and parity bits together. A mismatch sets `rx_err[1]`.
- R6: `two_stop`=1 samples two stop bits, and 0 samples one. Any stop sample that is low sets the framing flag `rx_err[2]`.
- R7: If every sampled data, parity and stop bit of a character is low, the break flag `rx_err[3]` is set. `rx_err[2]` is also set, and `rx_data` is 0.
- R8: A character completed while the previous one is still unacknowledged (`rx_taken` not pulsed since its strobe) sets the overrun flag `rx_err[0]`.
- R9: `rx_strobe` is high for exactly one clock per character. `rx_data` and `rx_err` change only together with the strobe and hold their values between strobes.
- R10: While `rst_n` is low at a clock edge, the block returns to idle with `rx_strobe`, `rx_data` and `rx_err` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversample clock enable, one clock wide |
| rx_pin | input | 1 | Asynchronous serial input, idle high |
| os_mode | input | 2 | Oversampling ratio select |
| word_len | input | 2 | Data-bit count select |
| parity_on | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 = even parity, 0 = odd |
| two_stop | input | 1 | 1 = two stop bits |
| rx_taken | input | 1 | Consumer has taken the current character |
| rx_strobe | output | 1 | Character valid, one clock |
| rx_data | output | 8 | Received character, right-aligned |
| rx_err | output | 4 | [0] overrun, [1] parity, [2] framing, [3] break |

## Verification
Characters are sent in every oversampling mode, including the reserved code. Mixed bit patterns such as 0xA5, 0x5A and alternating values are used so that bit-order or alignment mistakes show up in the received data. Each word length is paired with odd, even or no parity. Corrupted parity bits, low stop bits in one-stop and two-stop framing, and an all-zero break frame show that each error flag is raised on its own and in the right combination. Short low glitches in the fastest and slowest modes must produce nothing. Withheld acknowledges show that overrun depends only on the handshake.

// File: rtl/rxfe_pkg.sv
// Shared constants, state encoding and ratio decoding for the serial receiver.
// Assumes at most 16 oversample ticks per bit and at most 8 data bits.
package rxfe_pkg;
    localparam int MAX_OS   = 16;
    localparam int OS_CNT_W = $clog2(MAX_OS + 1);
    localparam int MAX_BITS = 8;
    localparam int IDX_W    = $clog2(MAX_BITS);
    localparam int ERR_W    = 4;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

    // Map the mode code to ticks per bit; the reserved code falls back to 16.
    function automatic logic [OS_CNT_W-1:0] os_ratio(input logic [1:0] mode);
        case (mode)
            2'b01:   return OS_CNT_W'(MAX_OS / 2);
            2'b10:   return OS_CNT_W'(MAX_OS / 4);
            default: return OS_CNT_W'(MAX_OS);
        endcase
    endfunction
endpackage

// File: rtl/rxfe_sync.sv
// Multi-stage synchronizer for an asynchronous level.
// Assumes the input is a slow level; the output resets to RST_VAL.
module rxfe_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxfe_centre_timer.sv
// Counts oversample ticks and flags each bit centre.
// After arm, the first centre comes `half` ticks later; each later one comes
// `full` ticks after the previous. Assumes half >= 1 and full >= 2.
module rxfe_centre_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         os_tick,
    input  logic         arm,
    input  logic         active,
    input  logic [W-1:0] half,
    input  logic [W-1:0] full,
    output logic         centre
);
    logic [W-1:0] cnt;
    logic [W-1:0] target;

    // A centre falls on the tick that completes the current interval.
    always_comb centre = active && os_tick && (cnt == target - W'(1));

    // Advance the tick count and reload the interval at each centre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            target <= '0;
        end else if (arm) begin
            cnt    <= '0;
            target <= half;
        end else if (active && os_tick) begin
            if (centre) begin
                cnt    <= '0;
                target <= full;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end
endmodule

// File: rtl/rxfe_framer.sv
// Character framing state machine: start validation, data assembly,
// parity and stop checks, error flags and overrun tracking.
// Assumes rx_s is already synchronized and that centre pulses come only while busy.
module rxfe_framer
    import rxfe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rx_s,
    input  logic                centre,
    input  logic [1:0]          word_len,
    input  logic                parity_on,
    input  logic                parity_even,
    input  logic                two_stop,
    input  logic                rx_taken,
    output logic                arm,
    output logic                busy,
    output logic                rx_strobe,
    output logic [MAX_BITS-1:0] rx_data,
    output logic [ERR_W-1:0]    rx_err
);
    rx_state_t           state;
    logic [IDX_W-1:0]    idx;
    logic                stop_idx;
    logic [MAX_BITS-1:0] shreg;
    logic                par_acc;
    logic                par_bad;
    logic                fe_acc;
    logic                all_low;
    logic                last_lvl;
    logic                unread;

    logic [IDX_W-1:0]    last_idx;
    logic                last_stop;
    logic                emit;
    logic                fe_final;
    logic                brk_final;
    logic [1:0]          align;

    // Decode the frame shape and the values of the closing stop sample.
    always_comb begin
        last_idx  = {1'b1, word_len};
        last_stop = !two_stop || stop_idx;
        emit      = centre && (state == RX_STOP) && last_stop;
        fe_final  = fe_acc | ~rx_s;
        brk_final = all_low & ~rx_s;
        align     = 2'd3 - word_len;
        arm       = (state == RX_IDLE) && os_tick && !rx_s && last_lvl;
        busy      = (state != RX_IDLE);
    end

    // Record the line level at every tick for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_lvl <= 1'b1;
        else if (os_tick) last_lvl <= rx_s;
    end

    // Walk the frame one centre sample at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            idx      <= '0;
            stop_idx <= 1'b0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            par_bad  <= 1'b0;
            fe_acc   <= 1'b0;
            all_low  <= 1'b1;
        end else begin
            case (state)
                RX_IDLE: if (arm) state <= RX_START;
                RX_START: if (centre) begin
                    if (rx_s) begin
                        state <= RX_IDLE;
                    end else begin
                        state    <= RX_DATA;
                        idx      <= '0;
                        stop_idx <= 1'b0;
                        par_acc  <= 1'b0;
                        par_bad  <= 1'b0;
                        fe_acc   <= 1'b0;
                        all_low  <= 1'b1;
                    end
                end
                RX_DATA: if (centre) begin
                    shreg   <= {rx_s, shreg[MAX_BITS-1:1]};
                    par_acc <= par_acc ^ rx_s;
                    all_low <= all_low & ~rx_s;
                    idx     <= idx + IDX_W'(1);
                    if (idx == last_idx) state <= parity_on ? RX_PARITY : RX_STOP;
                end
                RX_PARITY: if (centre) begin
                    par_bad <= par_acc ^ rx_s ^ ~parity_even;
                    all_low <= all_low & ~rx_s;
                    state   <= RX_STOP;
                end
                RX_STOP: if (centre) begin
                    fe_acc   <= fe_final;
                    all_low  <= brk_final;
                    stop_idx <= 1'b1;
                    if (last_stop) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // Track whether the last delivered character is still unacknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)        unread <= 1'b0;
        else if (emit)     unread <= 1'b1;
        else if (rx_taken) unread <= 1'b0;
    end

    // Present the character and its flags with a one-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_strobe <= 1'b0;
            rx_data   <= '0;
            rx_err    <= '0;
        end else begin
            rx_strobe <= emit;
            if (emit) begin
                rx_data <= shreg >> align;
                rx_err  <= {brk_final, fe_final, par_bad, unread & ~rx_taken};
            end
        end
    end
endmodule

// File: rtl/serial_rx_frontend.sv
// Serial receive front end: synchronizer, bit-centre timer and framer.
// Assumes os_tick is a one-clock enable at the oversample rate and the
// line-control inputs stay constant while a character is in flight.
module serial_rx_frontend
    import rxfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rx_pin,
    input  logic [1:0]          os_mode,
    input  logic [1:0]          word_len,
    input  logic                parity_on,
    input  logic                parity_even,
    input  logic                two_stop,
    input  logic                rx_taken,
    output logic                rx_strobe,
    output logic [MAX_BITS-1:0] rx_data,
    output logic [ERR_W-1:0]    rx_err
);
    logic                rx_s;
    logic                arm;
    logic                busy;
    logic                centre;
    logic [OS_CNT_W-1:0] full_ticks;
    logic [OS_CNT_W-1:0] half_ticks;

    // Derive the bit period and the start-bit offset from the mode.
    always_comb begin
        full_ticks = os_ratio(os_mode);
        half_ticks = full_ticks >> 1;
    end

    rxfe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_pin),
        .dout (rx_s)
    );

    rxfe_centre_timer #(.W(OS_CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .os_tick(os_tick),
        .arm    (arm),
        .active (busy),
        .half   (half_ticks),
        .full   (full_ticks),
        .centre (centre)
    );

    rxfe_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .rx_s       (rx_s),
        .centre     (centre),
        .word_len   (word_len),
        .parity_on  (parity_on),
        .parity_even(parity_even),
        .two_stop   (two_stop),
        .rx_taken   (rx_taken),
        .arm        (arm),
        .busy       (busy),
        .rx_strobe  (rx_strobe),
        .rx_data    (rx_data),
        .rx_err     (rx_err)
    );
endmodule

// File: rtl/rxfe_checker.sv
// Temporal checks on the receiver outputs, bound to the top module.
module rxfe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] word_len,
    input logic       rx_strobe,
    input logic [7:0] rx_data,
    input logic [3:0] rx_err
);
    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);
    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |-> $stable(rx_data) && $stable(rx_err));
    // R7
    break_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && rx_err[3]) |-> (rx_err[2] && rx_data == 8'h00));
    // R4
    short_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && word_len == 2'b00) |-> rx_data[7:5] == 3'b000);
    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (!rx_strobe && rx_err == 4'h0));
endmodule

bind serial_rx_frontend rxfe_checker u_rxfe_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_len (word_len),
    .rx_strobe(rx_strobe),
    .rx_data  (rx_data),
    .rx_err   (rx_err)
);

// File: tb/serial_rx_frontend_test.sv
`timescale 1ns/1ps
module serial_rx_frontend_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick;
    logic       rx_pin = 1'b1;
    logic [1:0] os_mode = 2'b00;
    logic [1:0] word_len = 2'b11;
    logic       parity_on = 1'b0;
    logic       parity_even = 1'b0;
    logic       two_stop = 1'b0;
    logic       rx_taken = 1'b0;
    logic       rx_strobe;
    logic [7:0] rx_data;
    logic [3:0] rx_err;

    int tests = 0;
    int fails = 0;
    int tcnt = 0;
    int cycles = 0;
    int strobes = 0;
    int expected_frames = 0;
    bit auto_take = 1'b1;
    bit unread = 1'b0;
    int exp_q[$];
    string req_q[$];

    localparam int TICK_DIV = 3;

    serial_rx_frontend uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin),
        .os_mode(os_mode), .word_len(word_len), .parity_on(parity_on),
        .parity_even(parity_even), .two_stop(two_stop), .rx_taken(rx_taken),
        .rx_strobe(rx_strobe), .rx_data(rx_data), .rx_err(rx_err)
    );

    always #2.5 clk = ~clk;

    // Oversample enable: one clock in every TICK_DIV.
    always @(negedge clk) tcnt <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
    assign os_tick = (tcnt == 0);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: every clock, compare a strobe with the next expected character.
    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            rx_taken <= 1'b0;
            if (rx_strobe) begin
                int e;
                int ovr;
                string rq;
                strobes++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected strobe", {rx_err, rx_data}, 0);
                end else begin
                    e = exp_q.pop_front();
                    rq = req_q.pop_front();
                    ovr = unread ? 1 : 0;
                    e = e | (ovr << 8);
                    check({rx_err, rx_data} == e[11:0], rq, {rx_err, rx_data}, e);
                end
                unread = 1'b1;
                if (auto_take) begin
                    rx_taken <= 1'b1;
                    unread = 1'b0;
                end
            end
        end
    end

    function automatic int ratio_of(input logic [1:0] m);
        return (m == 2'b01) ? 8 : (m == 2'b10) ? 4 : 16;
    endfunction

    task automatic drive_bit(input logic v);
        rx_pin = v;
        repeat (ratio_of(os_mode) * TICK_DIV) @(negedge clk);
    endtask

    // Send one frame with the current line settings and queue its expected result.
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop1_low,
                              input bit stop2_low, input string req);
        int n;
        logic [7:0] dm;
        logic pbit;
        logic perr;
        logic fe;
        logic brk;
        n = 5 + word_len;
        dm = d & 8'((1 << n) - 1);
        pbit = parity_even ? ^dm : ~^dm;
        if (bad_par) pbit = ~pbit;
        perr = parity_on && bad_par;
        fe = stop1_low || (two_stop && stop2_low);
        brk = (dm == 0) && (!parity_on || pbit == 1'b0) && stop1_low && (!two_stop || stop2_low);
        exp_q.push_back({brk, fe, perr, 1'b0, dm});
        req_q.push_back(req);
        expected_frames++;
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(dm[i]);
        if (parity_on) drive_bit(pbit);
        drive_bit(~stop1_low);
        if (two_stop) drive_bit(~stop2_low);
        rx_pin = 1'b1;
        repeat (2 * ratio_of(os_mode) * TICK_DIV) @(negedge clk);
    endtask

    task automatic glitch(input int clocks);
        rx_pin = 1'b0;
        repeat (clocks) @(negedge clk);
        rx_pin = 1'b1;
        repeat (3 * ratio_of(os_mode) * TICK_DIV) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] m, input logic [1:0] wl, input bit pon,
                         input bit pev, input bit ts);
        os_mode = m; word_len = wl; parity_on = pon; parity_even = pev; two_stop = ts;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", cycles, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: outputs quiet in reset
        check(rx_strobe == 1'b0 && rx_data == 8'h00 && rx_err == 4'h0, "R10 reset state",
              {rx_strobe, rx_err, rx_data}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        setup(2'b00, 2'b11, 1'b0, 1'b0, 1'b0);
        send_frame(8'hA5, 0, 0, 0, "R2 R4 16x 8N1 0xA5");
        setup(2'b01, 2'b10, 1'b1, 1'b1, 1'b0);
        send_frame(8'h5A, 0, 0, 0, "R2 R5 8x 7E1 0x5A");
        setup(2'b10, 2'b00, 1'b1, 1'b0, 1'b0);
        send_frame(8'h16, 0, 0, 0, "R2 R4 4x 5O1 0x16");
        setup(2'b11, 2'b01, 1'b0, 1'b0, 1'b1);
        send_frame(8'h2B, 0, 0, 0, "R2 reserved mode 6N2");
        setup(2'b00, 2'b11, 1'b1, 1'b1, 1'b0);
        send_frame(8'h81, 1, 0, 0, "R5 bad even parity");
        setup(2'b01, 2'b11, 1'b1, 1'b0, 1'b0);
        send_frame(8'h7E, 1, 0, 0, "R5 bad odd parity");
        setup(2'b10, 2'b11, 1'b0, 1'b0, 1'b0);
        send_frame(8'h55, 0, 1, 0, "R6 framing one stop");
        setup(2'b01, 2'b11, 1'b0, 1'b0, 1'b1);
        send_frame(8'hAA, 0, 0, 1, "R6 framing second stop");
        setup(2'b00, 2'b11, 1'b1, 1'b1, 1'b0);
        send_frame(8'h00, 0, 1, 0, "R7 break with parity");
        setup(2'b10, 2'b10, 1'b0, 1'b0, 1'b0);
        send_frame(8'h00, 0, 1, 0, "R7 R1 break then restart");
        send_frame(8'h3C, 0, 0, 0, "R1 after break");

        // R3: glitches shorter than half a bit
        setup(2'b10, 2'b11, 1'b0, 1'b0, 1'b0);
        glitch(3);
        setup(2'b00, 2'b11, 1'b0, 1'b0, 1'b0);
        glitch(12);
        check(strobes == expected_frames, "R3 false start ignored", strobes, expected_frames);
        send_frame(8'hC3, 0, 0, 0, "R3 clean frame after glitch");

        // R8: withheld acknowledge
        auto_take = 1'b0;
        setup(2'b10, 2'b11, 1'b0, 1'b0, 1'b0);
        send_frame(8'h11, 0, 0, 0, "R8 first unacknowledged");
        send_frame(8'h22, 0, 0, 0, "R8 overrun flagged");
        auto_take = 1'b1;
        send_frame(8'h33, 0, 0, 0, "R8 overrun persists until take");
        send_frame(8'h44, 0, 0, 0, "R8 cleared after take");

        repeat (20) @(negedge clk);
        // R9: one strobe per character, no extras
        check(strobes == expected_frames && exp_q.size() == 0, "R9 strobe count",
              strobes, expected_frames);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule